// File: doc/BRIEF.md
# Exception Control Register Unit

This block holds the privileged control state a processor consults when it leaves normal program flow. There are four registers. The first holds the mode stack and the per-level interrupt mask. The second holds the pending interrupt levels and the last exception code. The third holds the program counter of the interrupted instruction. The fourth holds the faulting address.

When the pipeline signals an exception, or when an enabled and unmasked interrupt is pending, the unit captures the current PC and records the cause. It then pushes the mode stack and, in the same cycle, raises a redirect strobe with the fixed handler address. A return strobe pops the mode stack. Kernel code reads and writes the registers by number through a move-from port and a move-to port. If user code touches either port, the access does nothing and the unit raises a privilege exception itself.

The unit is purely control state. It has no streaming data path, so all pins are plain level or strobe signals, sampled on the rising clock edge.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, all four registers read as zero. The unit is in kernel mode with interrupts disabled (`kernel_o`=1, no redirect).
- R2: Register numbers are 8 for the faulting address, 12 for status, 13 for cause and 14 for the exception PC; every other number reads 0. Status bit 0 is interrupt enable (1 = on), bit 1 is kernel/user (0 = kernel, 1 = user), bits 3:2 hold the previous pair, bits 5:4 the old pair and bits 15:11 the mask. Cause bits 5:2 hold the code and bits 15:11 the pending levels. Status and exception PC are writable from kernel mode; writes to cause and to the faulting-address register leave them unchanged.
- R3: In any cycle in which an exception is taken, `redirect_o` is 1 and `redirect_pc_o` is 0x80000080. An asserted `exc_take_i` is always taken.
- R4: On entry, the exception PC becomes `pc_i` and cause bits 5:2 become the code. The faulting address becomes `bad_addr_i` when `bad_addr_vld_i` accompanies `exc_take_i`.
- R5: On entry, status bits 5:0 shift left by two and the current pair becomes 0/0 (kernel, interrupts off).
- R6: A return (`rfe_i`) copies the previous pair into the current slot and the old pair into the previous slot, and leaves the old slot unchanged.
- R7: A pending bit sets on the cycle after its `irq_i` line is high and stays set until `irq_clr_i` clears it. If set and clear arrive in the same cycle, the set wins.
- R8: An interrupt is taken, with code 0, only when interrupt enable is 1 and some pending bit has its mask bit set. An external exception in the same cycle wins, and its code is recorded instead.
- R9: A move-to or move-from while in user mode changes no register and reads 0. It takes an exception with code 11, capturing `pc_i`.
- R10: The exception PC, cause code and status are not altered in a cycle without a taken exception, a return or a kernel write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction in the exception stage |
| exc_take_i | input | 1 | Pipeline exception strobe |
| exc_code_i | input | 4 | Code for the pipeline exception |
| bad_addr_vld_i | input | 1 | Faulting address accompanies the exception |
| bad_addr_i | input | 32 | Faulting address |
| irq_i | input | 5 | Hardware interrupt request lines, one per level |
| irq_clr_i | input | 5 | Per-level pending clear |
| rfe_i | input | 1 | Return-from-exception strobe |
| mf_rd_i | input | 1 | Move-from access strobe |
| mf_num_i | input | 5 | Move-from register number |
| mf_data_o | output | 32 | Move-from read data (combinational) |
| mt_en_i | input | 1 | Move-to write strobe |
| mt_num_i | input | 5 | Move-to register number |
| mt_data_i | input | 32 | Move-to write data |
| redirect_o | output | 1 | Exception taken this cycle |
| redirect_pc_o | output | 32 | Handler address |
| kernel_o | output | 1 | Current mode is kernel |

## Verification
The hardest state to reach is a pending interrupt that collides with other events. It must arrive while interrupts are disabled and then be released, or it must meet an external exception in the very cycle it becomes takeable. The stimulus first pulses the request lines with interrupt enable off, so the pending bits latch without effect. A kernel write then turns enable on, and the bench expects a redirect in the following cycle. In a later scenario the request is pulsed one cycle ahead of an external exception strobe, so that both causes are live in the same cycle and the recorded code shows which one won.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN     = 32;
  localparam int NLVL     = 5;
  localparam int CODE_W   = 4;
  localparam int RNUM_W   = 5;
  localparam int STK_D    = 3;
  localparam int MASK_LSB = 11;
  localparam int CODE_LSB = 2;
  localparam int STK_W    = 2 * STK_D;

  localparam logic [RNUM_W-1:0] RN_BADADDR = 5'd8;
  localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [RNUM_W-1:0] RN_EPC     = 5'd14;

  localparam logic [CODE_W-1:0] CODE_IRQ  = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd11;

  localparam logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0080;

  typedef struct packed {
    logic ku;
    logic ie;
  } mode_pair_t;
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import exc_ctrl_pkg::*;
#(
  parameter int DEPTH = STK_D,
  parameter int LVLS  = NLVL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              wr_i,
  input  logic [2*DEPTH-1:0] wr_stk_i,
  input  logic [LVLS-1:0]   wr_mask_i,
  output logic [2*DEPTH-1:0] stk_o,
  output logic [LVLS-1:0]   mask_o,
  output logic              cur_ku_o,
  output logic              cur_ie_o
);
  mode_pair_t slot_q [DEPTH];
  logic [LVLS-1:0] mask_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    mode_pair_t from_below;
    mode_pair_t from_above;
    if (g == 0) begin : g_bot
      assign from_below = '0;
    end else begin : g_mid
      assign from_below = slot_q[g-1];
    end
    if (g == DEPTH - 1) begin : g_top
      assign from_above = slot_q[g];
    end else begin : g_low
      assign from_above = slot_q[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push_i) begin
        slot_q[g] <= from_below;
      end else if (pop_i) begin
        slot_q[g] <= from_above;
      end else if (wr_i) begin
        slot_q[g] <= mode_pair_t'(wr_stk_i[2*g+1 -: 2]);
      end
    end

    assign stk_o[2*g+1 -: 2] = slot_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_i && !push_i && !pop_i) begin
      mask_q <= wr_mask_i;
    end
  end

  assign mask_o   = mask_q;
  assign cur_ku_o = slot_q[0].ku;
  assign cur_ie_o = slot_q[0].ie;
endmodule

// File: rtl/exc_pend_unit.sv
module exc_pend_unit
  import exc_ctrl_pkg::*;
#(
  parameter int LVLS = NLVL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLS-1:0] irq_i,
  input  logic [LVLS-1:0] clr_i,
  input  logic [LVLS-1:0] mask_i,
  input  logic            ie_i,
  output logic [LVLS-1:0] pend_o,
  output logic            int_req_o
);
  logic [LVLS-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | irq_i;
    end
  end

  assign pend_o    = pend_q;
  assign int_req_o = ie_i && (|(pend_q & mask_i));
endmodule

// File: rtl/exc_reg_read.sv
module exc_reg_read
  import exc_ctrl_pkg::*;
(
  input  logic [RNUM_W-1:0] num_i,
  input  logic [STK_W-1:0]  stk_i,
  input  logic [NLVL-1:0]   mask_i,
  input  logic [NLVL-1:0]   pend_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   bad_i,
  output logic [XLEN-1:0]   data_o
);
  logic [XLEN-1:0] status_w;
  logic [XLEN-1:0] cause_w;

  always_comb begin
    status_w = '0;
    status_w[STK_W-1:0] = stk_i;
    status_w[MASK_LSB +: NLVL] = mask_i;
    cause_w = '0;
    cause_w[CODE_LSB +: CODE_W] = code_i;
    cause_w[MASK_LSB +: NLVL] = pend_i;
  end

  always_comb begin
    unique case (num_i)
      RN_BADADDR: data_o = bad_i;
      RN_STATUS:  data_o = status_w;
      RN_CAUSE:   data_o = cause_w;
      RN_EPC:     data_o = epc_i;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              exc_take_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              bad_addr_vld_i,
  input  logic [XLEN-1:0]   bad_addr_i,
  input  logic [NLVL-1:0]   irq_i,
  input  logic [NLVL-1:0]   irq_clr_i,
  input  logic              rfe_i,
  input  logic              mf_rd_i,
  input  logic [RNUM_W-1:0] mf_num_i,
  output logic [XLEN-1:0]   mf_data_o,
  input  logic              mt_en_i,
  input  logic [RNUM_W-1:0] mt_num_i,
  input  logic [XLEN-1:0]   mt_data_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              kernel_o
);
  logic [STK_W-1:0]  stk_w;
  logic [NLVL-1:0]   mask_w;
  logic [NLVL-1:0]   pend_w;
  logic              cur_ku;
  logic              cur_ie;
  logic              int_req;
  logic              priv_viol;
  logic              take;
  logic              wr_ok;
  logic [CODE_W-1:0] code_sel;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   bad_q;
  logic [XLEN-1:0]   rd_w;

  // Arbitration: pipeline exception, then privilege trap, then interrupt.
  assign priv_viol = cur_ku && (mt_en_i || mf_rd_i);
  assign take      = exc_take_i || priv_viol || int_req;

  always_comb begin
    if (exc_take_i)     code_sel = exc_code_i;
    else if (priv_viol) code_sel = CODE_PRIV;
    else                code_sel = CODE_IRQ;
  end

  assign wr_ok = mt_en_i && !cur_ku && !take;

  exc_mode_stack #(.DEPTH(STK_D), .LVLS(NLVL)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (take),
    .pop_i     (rfe_i && !take),
    .wr_i      (wr_ok && (mt_num_i == RN_STATUS)),
    .wr_stk_i  (mt_data_i[STK_W-1:0]),
    .wr_mask_i (mt_data_i[MASK_LSB +: NLVL]),
    .stk_o     (stk_w),
    .mask_o    (mask_w),
    .cur_ku_o  (cur_ku),
    .cur_ie_o  (cur_ie)
  );

  exc_pend_unit #(.LVLS(NLVL)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_i),
    .clr_i     (irq_clr_i),
    .mask_i    (mask_w),
    .ie_i      (cur_ie),
    .pend_o    (pend_w),
    .int_req_o (int_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q  <= '0;
      code_q <= '0;
      bad_q  <= '0;
    end else begin
      if (take) begin
        epc_q  <= pc_i;
        code_q <= code_sel;
      end else if (wr_ok && (mt_num_i == RN_EPC)) begin
        epc_q <= mt_data_i;
      end
      if (exc_take_i && bad_addr_vld_i) begin
        bad_q <= bad_addr_i;
      end
    end
  end

  exc_reg_read u_read (
    .num_i  (mf_num_i),
    .stk_i  (stk_w),
    .mask_i (mask_w),
    .pend_i (pend_w),
    .code_i (code_q),
    .epc_i  (epc_q),
    .bad_i  (bad_q),
    .data_o (rd_w)
  );

  assign mf_data_o     = cur_ku ? '0 : rd_w;
  assign redirect_o    = take;
  assign redirect_pc_o = HANDLER_VEC;
  assign kernel_o      = !cur_ku;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk
  import exc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic              exc_take_i,
  input logic              mt_en_i,
  input logic [RNUM_W-1:0] mt_num_i,
  input logic              mf_rd_i,
  input logic [NLVL-1:0]   irq_clr_i,
  input logic              redirect_o,
  input logic [XLEN-1:0]   redirect_pc_o,
  input logic              cur_ku,
  input logic              cur_ie,
  input logic [XLEN-1:0]   epc_q,
  input logic [NLVL-1:0]   pend_w
);
  AST_VECTOR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_pc_o == HANDLER_VEC)); // R3

  AST_EXT_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_i |-> redirect_o); // R3

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (epc_q == $past(pc_i))); // R4

  AST_ENTRY_KERNEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (!cur_ku && !cur_ie)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_w & ~irq_clr_i)) |=> ((pend_w & $past(pend_w & ~irq_clr_i)) == $past(pend_w & ~irq_clr_i))); // R7

  AST_USER_ACCESS_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ku && (mt_en_i || mf_rd_i)) |-> redirect_o); // R9

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_o && !(mt_en_i && mt_num_i == RN_EPC)) |=> $stable(epc_q)); // R10
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_i          (pc_i),
  .exc_take_i    (exc_take_i),
  .mt_en_i       (mt_en_i),
  .mt_num_i      (mt_num_i),
  .mf_rd_i       (mf_rd_i),
  .irq_clr_i     (irq_clr_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .cur_ku        (cur_ku),
  .cur_ie        (cur_ie),
  .epc_q         (epc_q),
  .pend_w        (pend_w)
);

// File: tb/exc_ctrl_regs_tb.sv
module exc_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic        exc_take_i = 1'b0;
  logic [3:0]  exc_code_i = '0;
  logic        bad_addr_vld_i = 1'b0;
  logic [31:0] bad_addr_i = '0;
  logic [4:0]  irq_i = '0;
  logic [4:0]  irq_clr_i = '0;
  logic        rfe_i = 1'b0;
  logic        mf_rd_i = 1'b0;
  logic [4:0]  mf_num_i = '0;
  logic [31:0] mf_data_o;
  logic        mt_en_i = 1'b0;
  logic [4:0]  mt_num_i = '0;
  logic [31:0] mt_data_i = '0;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic        kernel_o;

  always #10 clk = ~clk;

  exc_ctrl_regs u_dut (.*);

  typedef struct {
    int          kind;   // 0 read data, 1 redirect+vector, 2 kernel flag
    logic [32:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Monitor: compares every item pushed during this cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [32:0] obs;
      it = sbq.pop_front();
      case (it.kind)
        0:       obs = {1'b0, mf_data_o};
        1:       obs = {redirect_o, redirect_o ? redirect_pc_o : 32'h0};
        default: obs = {32'h0, kernel_o};
      endcase
      checks++;
      if (obs !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, obs, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
    exc_take_i = 0; exc_code_i = 0; bad_addr_vld_i = 0; bad_addr_i = 0;
    irq_i = 0; irq_clr_i = 0; rfe_i = 0; mf_rd_i = 0; mf_num_i = 0;
    mt_en_i = 0; mt_num_i = 0; mt_data_i = 0;
  endtask

  task automatic exp_rd(input logic [4:0] num, input logic [31:0] v, input string tag);
    item_t it;
    mf_rd_i = 1; mf_num_i = num;
    it.kind = 0; it.exp = {1'b0, v}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_redir(input bit r, input string tag);
    item_t it;
    it.kind = 1; it.exp = r ? {1'b1, 32'h8000_0080} : 33'h0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_kern(input bit k, input string tag);
    item_t it;
    it.kind = 2; it.exp = {32'h0, k}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic rd(input logic [4:0] num, input logic [31:0] v, input string tag);
    cyc(); exp_rd(num, v, tag);
  endtask

  task automatic wr(input logic [4:0] num, input logic [31:0] v);
    cyc(); mt_en_i = 1; mt_num_i = num; mt_data_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    cyc(); exp_kern(1, "R1 kernel"); exp_redir(0, "R1 no redirect");
    rd(12, 32'h0, "R1 status");
    rd(13, 32'h0, "R1 cause");
    rd(14, 32'h0, "R1 epc");
    rd(8,  32'h0, "R1 badaddr");
    rd(9,  32'h0, "R2 unmapped");
    // R3/R4/R5 entry from status 0x04
    wr(12, 32'h4);
    cyc(); exc_take_i = 1; exc_code_i = 6; pc_i = 32'h1000; exp_redir(1, "R3 take");
    rd(12, 32'h10, "R5 shift");
    rd(13, 32'h18, "R4 code");
    rd(14, 32'h1000, "R4 epc");
    // R6 returns
    cyc(); rfe_i = 1;
    rd(12, 32'h14, "R6 pop1");
    cyc(); rfe_i = 1;
    rd(12, 32'h15, "R6 pop2");
    // R4 bad address capture
    cyc(); exc_take_i = 1; exc_code_i = 4; pc_i = 32'h1100;
    bad_addr_vld_i = 1; bad_addr_i = 32'hBAD0; exp_redir(1, "R3 take2");
    rd(8,  32'hBAD0, "R4 badaddr");
    rd(13, 32'h10, "R4 code2");
    rd(12, 32'h14, "R5 shift2");
    // R2 writability
    wr(14, 32'h4444);
    rd(14, 32'h4444, "R2 epc write");
    wr(13, 32'hFFFF);
    rd(13, 32'h10, "R2 cause readonly");
    wr(8, 32'h1234);
    rd(8, 32'hBAD0, "R2 badaddr readonly");
    // R9 user write
    wr(12, 32'h2);
    cyc(); exp_kern(0, "R9 user mode");
    cyc(); mt_en_i = 1; mt_num_i = 14; mt_data_i = 32'hDEAD; pc_i = 32'h2000;
    exp_redir(1, "R9 write trap");
    rd(14, 32'h2000, "R9 write ignored");
    rd(13, 32'h2C, "R9 code");
    rd(12, 32'h08, "R9 status");
    // R9 user read
    wr(12, 32'h2);
    cyc(); pc_i = 32'h2100; exp_rd(12, 32'h0, "R9 read zero"); exp_redir(1, "R9 read trap");
    rd(14, 32'h2100, "R9 read epc");
    // R7/R8 pending with interrupts disabled
    wr(12, 32'h2000);
    cyc(); irq_i = 5'b00101;
    cyc(); exp_rd(13, 32'h282C, "R7 pend set"); exp_redir(0, "R8 ie off");
    cyc(); exp_redir(0, "R8 ie off hold");
    wr(12, 32'h2001); exp_redir(0, "R8 before enable");
    cyc(); pc_i = 32'h3000; exp_redir(1, "R8 irq taken");
    rd(14, 32'h3000, "R8 epc");
    rd(13, 32'h2800, "R8 code zero");
    rd(12, 32'h2004, "R5 irq shift");
    // R7 clear and masking
    cyc(); irq_clr_i = 5'b00100;
    rd(13, 32'h0800, "R7 clear one");
    wr(12, 32'h0001);
    cyc(); exp_redir(0, "R8 masked");
    cyc(); irq_i = 5'b00001; irq_clr_i = 5'b00001;
    rd(13, 32'h0800, "R7 set wins");
    cyc(); irq_clr_i = 5'b00001;
    rd(13, 32'h0, "R7 cleared");
    // R10 hold
    wr(12, 32'h0);
    cyc(); pc_i = 32'h7777;
    cyc(); pc_i = 32'h8888; irq_i = 5'b00010;
    rd(14, 32'h3000, "R10 epc hold");
    rd(12, 32'h0, "R10 status hold");
    // R8 priority: external over interrupt
    cyc(); irq_clr_i = 5'b11111;
    wr(12, 32'hF801);
    cyc(); irq_i = 5'b00001; exp_redir(0, "R8 not yet");
    cyc(); exc_take_i = 1; exc_code_i = 9; pc_i = 32'h5000; exp_redir(1, "R8 both");
    rd(13, 32'h0824, "R8 external wins");
    rd(14, 32'h5000, "R8 epc");
    cyc();
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule